// File: doc/BRIEF.md
# Switch Configuration Register File with Host Lock

This block is the standard capability and status register space of a small packet switch. A single 32-bit configuration bus reaches it: each request carries a byte offset (the two low bits are ignored, so every access is one whole word), a write flag, write data and the number of the port the request arrived on. One cycle later the block acknowledges the request, and for reads it returns the word.

Most of the space is constant. It holds the identity, revision and feature words, plus a word that gives the number of ports and the accessing port. The writable state is a component tag, a 24-bit link timeout, a discovered flag, and an output enable and an input enable for each port. The timeout and the enables also leave the block on output pins, where the port logic consumes them. Each port has a status word that reflects its link-initialised input. A host base device ID lock lets one host claim the device by writing its ID. Only a write of that same ID releases the lock.

Top module: `sw_cfg_regs`

## Requirements
- R1: Offset 0x00 reads {DEV_ID, DEV_VENDOR}, 0x04 reads DEV_REV, 0x08 reads {ASSY_ID, ASSY_VENDOR}, and 0x0C reads {ASSY_REV, 16'h0100}.
- R2: Offset 0x10 reads 32'h10000118. Offset 0x14 reads NUM_PORTS in bits 15..8 and the requesting port number src_port_i in bits 7..0, with zeros above.
- R3: The lock word at 0x68 reads 32'h0000FFFF after reset. A write while it reads 0xFFFF stores wdata_i[15..0], which then reads back in bits 15..0 with zeros above.
- R4: While the lock holds an ID other than 0xFFFF, a write of a different 16-bit value leaves it unchanged. A write of the held value returns it to 0xFFFF.
- R5: The component tag at 0x6C resets to 0 and reads back any 32-bit value written to it.
- R6: The link timeout at 0x120 keeps wdata_i[31..8] and reads as {timeout, 8'h00}. It resets to 24'hFFFFFF. link_timeout_o always equals the stored value.
- R7: General control at 0x13C resets to 0. Bit 29 is a read/write discovered flag, and every other bit reads 0.
- R8: The status of port n, at 0x158 + 0x20*n, reads 1 while link_up_i[n] is low and 2 while it is high. Its value is taken in the cycle of the request.
- R9: The control word of port n, at 0x15C + 0x20*n, reads bit 0 as 1, bit 22 as the output enable and bit 21 as the input enable, and all other bits as 0. Both enables reset to 0, and they drive out_en_o[n] and in_en_o[n].
- R10: A read of any offset not listed here returns 0. A write to such an offset, or to a read-only word, changes no register and no output.
- R11: Each request cycle produces ack_o high in the next cycle, and ack_o is low after a cycle without a request. A write acknowledge returns 0 on rdata_o. Address bits 1..0 do not affect the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte offset of the word |
| wdata_i | input | 32 | Write data |
| src_port_i | input | 8 | Port number the request came in on |
| ack_o | output | 1 | Acknowledge, one cycle after the request |
| rdata_o | output | 32 | Read data, valid with ack_o |
| link_up_i | input | NUM_PORTS | Link-initialised flag per port |
| link_timeout_o | output | 24 | Stored link timeout |
| out_en_o | output | NUM_PORTS | Output port enable per port |
| in_en_o | output | NUM_PORTS | Input port enable per port |

## Verification
The bench builds the block with NUM_PORTS = 4 rather than the default of 3, so the port-count field and the last port's words, at 0x1B8 and 0x1BC, are exercised at a size the default never reaches. Each identity parameter gets a different non-zero value, so a swapped half-word or a swapped word shows up on R1. The random phase draws offsets from every mapped word, from unmapped words and from words just past the last port. It also draws lock write values close to the current holder, which reaches both the release path and the ignore path of the lock many times.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;
  localparam int CFG_AW = 24;
  localparam int CFG_DW = 32;
  localparam int ID_W   = 16;
  localparam int TMO_W  = 24;

  localparam logic [CFG_AW-1:0] OFS_DEV_ID    = 24'h000000;
  localparam logic [CFG_AW-1:0] OFS_DEV_REV   = 24'h000004;
  localparam logic [CFG_AW-1:0] OFS_ASSY_ID   = 24'h000008;
  localparam logic [CFG_AW-1:0] OFS_ASSY_INFO = 24'h00000C;
  localparam logic [CFG_AW-1:0] OFS_FEAT      = 24'h000010;
  localparam logic [CFG_AW-1:0] OFS_SWPORT    = 24'h000014;
  localparam logic [CFG_AW-1:0] OFS_LOCK      = 24'h000068;
  localparam logic [CFG_AW-1:0] OFS_TAG       = 24'h00006C;
  localparam logic [CFG_AW-1:0] OFS_TMO       = 24'h000120;
  localparam logic [CFG_AW-1:0] OFS_GEN       = 24'h00013C;
  localparam logic [CFG_AW-1:0] OFS_PORT_ST   = 24'h000158;
  localparam logic [CFG_AW-1:0] OFS_PORT_CT   = 24'h00015C;
  localparam int                PORT_STRIDE   = 32'h20;

  localparam logic [CFG_DW-1:0] FEAT_WORD  = 32'h10000118;
  localparam logic [ID_W-1:0]   ASSY_EXT   = 16'h0100;
  localparam logic [ID_W-1:0]   LOCK_FREE  = 16'hFFFF;
  localparam logic [TMO_W-1:0]  TMO_RESET  = 24'hFFFFFF;

  localparam int BIT_DISC = 29;
  localparam int BIT_OEN  = 22;
  localparam int BIT_IEN  = 21;

  localparam logic [CFG_DW-1:0] ST_UNINIT = 32'h1;
  localparam logic [CFG_DW-1:0] ST_OK     = 32'h2;
endpackage

// File: rtl/cfg_lock.sv
module cfg_lock
  import cfg_regs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [ID_W-1:0] wid_i,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_q;
  logic            free;

  assign free = (id_q == LOCK_FREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= LOCK_FREE;
    end else if (wr_i) begin
      if (free)               id_q <= wid_i;
      else if (wid_i == id_q) id_q <= LOCK_FREE;
    end
  end

  assign id_o = id_q;
endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
  import cfg_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_wr_i,
  input  logic              tmo_wr_i,
  input  logic              gen_wr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_DW-1:0] tag_o,
  output logic [TMO_W-1:0]  tmo_o,
  output logic              disc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o  <= '0;
      tmo_o  <= TMO_RESET;
      disc_o <= 1'b0;
    end else begin
      if (tag_wr_i) tag_o  <= wdata_i;
      if (tmo_wr_i) tmo_o  <= wdata_i[CFG_DW-1 -: TMO_W];
      if (gen_wr_i) disc_o <= wdata_i[BIT_DISC];
    end
  end
endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank
  import cfg_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              link_up_i,
  output logic [CFG_DW-1:0] stat_o,
  output logic [CFG_DW-1:0] ctrl_o,
  output logic              out_en_o,
  output logic              in_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_en_o <= 1'b0;
      in_en_o  <= 1'b0;
    end else if (ctrl_wr_i) begin
      out_en_o <= wdata_i[BIT_OEN];
      in_en_o  <= wdata_i[BIT_IEN];
    end
  end

  assign stat_o = link_up_i ? ST_OK : ST_UNINIT;

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[0]       = 1'b1;
    ctrl_o[BIT_OEN] = out_en_o;
    ctrl_o[BIT_IEN] = in_en_o;
  end
endmodule

// File: rtl/sw_cfg_regs.sv
module sw_cfg_regs
  import cfg_regs_pkg::*;
#(
  parameter int              NUM_PORTS   = 3,
  parameter logic [ID_W-1:0] DEV_ID      = 16'h0001,
  parameter logic [ID_W-1:0] DEV_VENDOR  = 16'h0002,
  parameter logic [31:0]     DEV_REV     = 32'h00000001,
  parameter logic [ID_W-1:0] ASSY_ID     = 16'h0003,
  parameter logic [ID_W-1:0] ASSY_VENDOR = 16'h0004,
  parameter logic [ID_W-1:0] ASSY_REV    = 16'h0005
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [CFG_AW-1:0]    addr_i,
  input  logic [CFG_DW-1:0]    wdata_i,
  input  logic [7:0]           src_port_i,
  output logic                 ack_o,
  output logic [CFG_DW-1:0]    rdata_o,
  input  logic [NUM_PORTS-1:0] link_up_i,
  output logic [TMO_W-1:0]     link_timeout_o,
  output logic [NUM_PORTS-1:0] out_en_o,
  output logic [NUM_PORTS-1:0] in_en_o
);
  localparam logic [7:0] PORT_CNT = 8'(NUM_PORTS);

  logic [CFG_AW-1:0] waddr;
  logic              wr;
  logic [ID_W-1:0]   lock_id;
  logic [CFG_DW-1:0] tag;
  logic              disc;
  logic [CFG_DW-1:0] rd_fixed, rd_port, rd_word;
  logic [CFG_DW-1:0] port_rd [NUM_PORTS];
  logic              ack_q;
  logic [CFG_DW-1:0] rdata_q;

  assign waddr = {addr_i[CFG_AW-1:2], 2'b00};
  assign wr    = req_i & we_i;

  cfg_lock u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr && (waddr == OFS_LOCK)),
    .wid_i  (wdata_i[ID_W-1:0]),
    .id_o   (lock_id)
  );

  cfg_ctrl_regs u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tag_wr_i (wr && (waddr == OFS_TAG)),
    .tmo_wr_i (wr && (waddr == OFS_TMO)),
    .gen_wr_i (wr && (waddr == OFS_GEN)),
    .wdata_i  (wdata_i),
    .tag_o    (tag),
    .tmo_o    (link_timeout_o),
    .disc_o   (disc)
  );

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    localparam logic [CFG_AW-1:0] ST_A = OFS_PORT_ST + CFG_AW'(PORT_STRIDE * n);
    localparam logic [CFG_AW-1:0] CT_A = OFS_PORT_CT + CFG_AW'(PORT_STRIDE * n);
    logic [CFG_DW-1:0] stat, ctrl;

    cfg_port_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_wr_i (wr && (waddr == CT_A)),
      .wdata_i   (wdata_i),
      .link_up_i (link_up_i[n]),
      .stat_o    (stat),
      .ctrl_o    (ctrl),
      .out_en_o  (out_en_o[n]),
      .in_en_o   (in_en_o[n])
    );

    assign port_rd[n] = ((waddr == ST_A) ? stat : '0) |
                        ((waddr == CT_A) ? ctrl : '0);
  end

  always_comb begin
    rd_port = '0;
    for (int k = 0; k < NUM_PORTS; k++) rd_port |= port_rd[k];
  end

  always_comb begin
    rd_fixed = '0;
    case (waddr)
      OFS_DEV_ID:    rd_fixed = {DEV_ID, DEV_VENDOR};
      OFS_DEV_REV:   rd_fixed = DEV_REV;
      OFS_ASSY_ID:   rd_fixed = {ASSY_ID, ASSY_VENDOR};
      OFS_ASSY_INFO: rd_fixed = {ASSY_REV, ASSY_EXT};
      OFS_FEAT:      rd_fixed = FEAT_WORD;
      OFS_SWPORT:    rd_fixed = {16'h0, PORT_CNT, src_port_i};
      OFS_LOCK:      rd_fixed = {{(CFG_DW-ID_W){1'b0}}, lock_id};
      OFS_TAG:       rd_fixed = tag;
      OFS_TMO:       rd_fixed = {link_timeout_o, {(CFG_DW-TMO_W){1'b0}}};
      OFS_GEN:       rd_fixed[BIT_DISC] = disc;
      default:       rd_fixed = '0;
    endcase
  end

  assign rd_word = rd_fixed | rd_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= req_i;
      if (req_i) rdata_q <= we_i ? '0 : rd_word;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cfg_regs_chk.sv
module cfg_regs_chk
  import cfg_regs_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [CFG_AW-1:0]    addr_i,
  input logic [CFG_DW-1:0]    wdata_i,
  input logic                 ack_o,
  input logic [CFG_DW-1:0]    rdata_o,
  input logic [TMO_W-1:0]     link_timeout_o,
  input logic [NUM_PORTS-1:0] out_en_o,
  input logic [NUM_PORTS-1:0] in_en_o,
  input logic [ID_W-1:0]      lock_id
);
  logic lock_wr;
  assign lock_wr = req_i && we_i && ({addr_i[CFG_AW-1:2], 2'b00} == OFS_LOCK);

  a_r11_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  a_r11_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  a_r11_write_ack_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (rdata_o == '0));
  a_r4_foreign_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr && lock_id != LOCK_FREE && wdata_i[ID_W-1:0] != lock_id) |=> $stable(lock_id));
  a_r4_owner_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr && lock_id != LOCK_FREE && wdata_i[ID_W-1:0] == lock_id) |=> (lock_id == LOCK_FREE));
  a_r3_free_acquire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_wr && lock_id == LOCK_FREE) |=> (lock_id == $past(wdata_i[ID_W-1:0])));
  a_r6_timeout_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(link_timeout_o));
  a_r9_enables_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(out_en_o) && $stable(in_en_o)));
endmodule

bind sw_cfg_regs cfg_regs_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .ack_o          (ack_o),
  .rdata_o        (rdata_o),
  .link_timeout_o (link_timeout_o),
  .out_en_o       (out_en_o),
  .in_en_o        (in_en_o),
  .lock_id        (lock_id)
);

// File: tb/sim_sw_cfg_regs.sv
`timescale 1ns/1ps
module sim_sw_cfg_regs;
  localparam int NP = 4;
  localparam logic [15:0] P_DEV_ID = 16'h0123, P_DEV_VEN = 16'h4567;
  localparam logic [31:0] P_DEV_REV = 32'h89ABCDEF;
  localparam logic [15:0] P_ASSY_ID = 16'h0011, P_ASSY_VEN = 16'h2233, P_ASSY_REV = 16'h4455;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [23:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [7:0]    src = '0;
  logic          ack;
  logic [31:0]   rdata;
  logic [NP-1:0] link = '0;
  logic [23:0]   tmo_o;
  logic [NP-1:0] oen_o, ien_o;

  sw_cfg_regs #(
    .NUM_PORTS(NP), .DEV_ID(P_DEV_ID), .DEV_VENDOR(P_DEV_VEN), .DEV_REV(P_DEV_REV),
    .ASSY_ID(P_ASSY_ID), .ASSY_VENDOR(P_ASSY_VEN), .ASSY_REV(P_ASSY_REV)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .src_port_i(src), .ack_o(ack), .rdata_o(rdata),
    .link_up_i(link), .link_timeout_o(tmo_o), .out_en_o(oen_o), .in_en_o(ien_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [15:0]   m_lock;
  logic [31:0]   m_tag;
  logic [23:0]   m_tmo;
  logic          m_disc;
  logic [NP-1:0] m_oen, m_ien;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [23:0] a_in, input logic [7:0] sp);
    logic [23:0] a;
    a = {a_in[23:2], 2'b00};
    case (a)
      24'h000: return {P_DEV_ID, P_DEV_VEN};
      24'h004: return P_DEV_REV;
      24'h008: return {P_ASSY_ID, P_ASSY_VEN};
      24'h00C: return {P_ASSY_REV, 16'h0100};
      24'h010: return 32'h10000118;
      24'h014: return {16'h0, 8'(NP), sp};
      24'h068: return {16'h0, m_lock};
      24'h06C: return m_tag;
      24'h120: return {m_tmo, 8'h00};
      24'h13C: return {2'b00, m_disc, 29'h0};
      default: ;
    endcase
    for (int p = 0; p < NP; p++) begin
      if (a == 24'h158 + 24'(32 * p)) return link[p] ? 32'h2 : 32'h1;
      if (a == 24'h15C + 24'(32 * p)) return 32'h1 | (32'(m_oen[p]) << 22) | (32'(m_ien[p]) << 21);
    end
    return 32'h0;
  endfunction

  function automatic string req_of(input logic [23:0] a_in);
    logic [23:0] a;
    a = {a_in[23:2], 2'b00};
    if (a <= 24'h00C) return "R1";
    if (a == 24'h010 || a == 24'h014) return "R2";
    if (a == 24'h068) return "R3/R4";
    if (a == 24'h06C) return "R5";
    if (a == 24'h120) return "R6";
    if (a == 24'h13C) return "R7";
    for (int p = 0; p < NP; p++) begin
      if (a == 24'h158 + 24'(32 * p)) return "R8";
      if (a == 24'h15C + 24'(32 * p)) return "R9";
    end
    return "R10";
  endfunction

  function automatic void model_wr(input logic [23:0] a_in, input logic [31:0] d);
    logic [23:0] a;
    a = {a_in[23:2], 2'b00};
    if (a == 24'h068) begin
      if (m_lock == 16'hFFFF) m_lock = d[15:0];
      else if (d[15:0] == m_lock) m_lock = 16'hFFFF;
    end
    if (a == 24'h06C) m_tag = d;
    if (a == 24'h120) m_tmo = d[31:8];
    if (a == 24'h13C) m_disc = d[29];
    for (int p = 0; p < NP; p++)
      if (a == 24'h15C + 24'(32 * p)) begin
        m_oen[p] = d[22];
        m_ien[p] = d[21];
      end
  endfunction

  task automatic check_outs();
    check("R6", {8'h0, tmo_o}, {8'h0, m_tmo}, "link_timeout_o");
    check("R9", 32'(oen_o), 32'(m_oen), "out_en_o");
    check("R9", 32'(ien_o), 32'(m_ien), "in_en_o");
  endtask

  // one access; inputs driven at negedge, results sampled one cycle later at negedge
  task automatic access(input logic w, input logic [23:0] a, input logic [31:0] d, input logic [7:0] sp);
    logic [31:0] e;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; src = sp;
    e = w ? 32'h0 : exp_rd(a, sp);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R11", 32'(ack), 32'h1, "ack after request");
    if (w) begin
      check("R11", rdata, 32'h0, "write ack data");
      model_wr(a, d);
    end else begin
      check(req_of(a), rdata, e, $sformatf("read @%h", a));
    end
    check_outs();
  endtask

  task automatic rd(input logic [23:0] a); access(1'b0, a, 32'h0, 8'h05); endtask
  task automatic wr(input logic [23:0] a, input logic [31:0] d); access(1'b1, a, d, 8'h05); endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    m_lock = 16'hFFFF; m_tag = '0; m_tmo = 24'hFFFFFF; m_disc = 1'b0; m_oen = '0; m_ien = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R11", 32'(ack), 32'h0, "ack idle after reset");
    check_outs();

    // R1 / R2 identity and feature words
    rd(24'h000); rd(24'h004); rd(24'h008); rd(24'h00C); rd(24'h010);
    access(1'b0, 24'h014, 32'h0, 8'h00);
    access(1'b0, 24'h014, 32'h0, 8'hC3);
    rd(24'h00E); // R11 low bits ignored
    // R5 / R6 / R7 reset values and writes
    rd(24'h06C); wr(24'h06C, 32'hFFFFFFFF); rd(24'h06C);
    rd(24'h120); wr(24'h120, 32'h00000100); rd(24'h120);
    rd(24'h13C); wr(24'h13C, 32'hFFFFFFFF); rd(24'h13C); wr(24'h13C, 32'h0); rd(24'h13C);
    // R3 / R4 lock sequence
    rd(24'h068); wr(24'h068, 32'h2); rd(24'h068);
    wr(24'h068, 32'h3); rd(24'h068);
    wr(24'h068, 32'h2); rd(24'h068);
    wr(24'h068, 32'h3); rd(24'h068);
    wr(24'h068, 32'h3); rd(24'h068);
    // R8 per-port status, R9 control
    for (int p = 0; p < NP; p++) begin
      link[p] = 1'b0; rd(24'h158 + 24'(32 * p));
      link[p] = 1'b1; rd(24'h158 + 24'(32 * p));
      rd(24'h15C + 24'(32 * p));
      wr(24'h15C + 24'(32 * p), 32'h00600001);
      rd(24'h15C + 24'(32 * p));
    end
    // R10 read-only and unmapped writes
    wr(24'h000, 32'hDEADBEEF); rd(24'h000);
    wr(24'h158, 32'hFFFFFFFF); rd(24'h158);
    wr(24'h1D8, 32'hFFFFFFFF); rd(24'h1D8); rd(24'h1DC); rd(24'h200);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      logic [23:0] a;
      logic [31:0] d;
      logic        w;
      int sel;
      link = NP'($urandom);
      sel = int'($urandom_range(0, 15));
      case (sel)
        0: a = 24'h068;
        1: a = 24'h06C;
        2: a = 24'h120;
        3: a = 24'h13C;
        4, 5: a = 24'h158 + 24'(32 * $urandom_range(0, NP));
        6, 7: a = 24'h15C + 24'(32 * $urandom_range(0, NP));
        8: a = 24'(4 * $urandom_range(0, 6));
        9: a = 24'h068;
        default: a = 24'($urandom_range(0, 24'h3FF));
      endcase
      a[1:0] = 2'($urandom);
      w = 1'($urandom);
      d = $urandom;
      if (a[23:2] == 22'h1A && $urandom_range(0, 1) == 1) d[15:0] = m_lock;
      else if (a[23:2] == 22'h1A) d[15:0] = 16'($urandom_range(0, 3));
      access(w, a, d, 8'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R11", 32'(ack), 32'h0, "ack idle");
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule